// File: doc/BRIEF.md
# Channel Buffer Status Flags

This block keeps the status flags of one bus channel that sits between a host serial register port and a bus transfer engine. It records whether the transmit buffer can take a new word and whether the receive buffer holds data the host has not read yet. It also latches a driver shutdown when the driver reports over-current for too long while signalling. The host serial interface reports each end of a burst as a chip-select rising-edge strobe. That strobe is tagged to say whether the burst wrote the transmit registers or read the status register. Flags that the host consumes change only on that strobe, and never partway through a burst.

The engine reports when it has finished sending the buffered word, when it has written a received word, and when a new transaction starts. A supply-low indication that lasts longer than a mask time during a transaction marks that transaction's received word as untrustworthy, so the receive flag is not raised for it. The packed status byte ends in two constant bits, 0 then 1. These are the last two bits shifted out MSB-first, so the host can spot a burst with one clock too many or too few.

Top module: `chan_status_flags`

## Requirements
- R1: After reset, status_o is 8'h81 (transmit-empty 1, shutdown 0, receive-full 0, fixed bits 01) and drv_disable and tx_load are 0.
- R2: A strobe (cs_rise with cs_wr_tx) while transmit-empty is 1 pulses tx_load in the same cycle, and transmit-empty (status_o[7]) reads 0 from the next cycle on.
- R3: A strobe (cs_rise with cs_wr_tx) while transmit-empty is 0 leaves tx_load at 0 and leaves status_o unchanged.
- R4: tx_done sets transmit-empty to 1 in the next cycle. This also holds when a transmit write strobe arrives in the same cycle.
- R5: rx_wr sets receive-full (status_o[5]) to 1 in the next cycle, unless the current transaction is supply-qualified (R7).
- R6: A strobe (cs_rise with cs_rd_stat) clears receive-full in the next cycle. An rx_wr in the same cycle takes priority and leaves the flag at 1.
- R7: If supply_low is high for more than SUPPLY_MASK_CYC consecutive cycles since the last xfer_start, any rx_wr before the next xfer_start leaves receive-full unchanged. A run of exactly SUPPLY_MASK_CYC cycles does not suppress it.
- R8: If oc_hi or oc_lo is high while sig_mode is 1 for more than OC_DELAY_CYC consecutive cycles, shutdown (status_o[6]) and drv_disable are 1 from the next cycle. A run of exactly OC_DELAY_CYC cycles, or any run while sig_mode is 0, leaves both at 0.
- R9: Once set, shutdown and drv_disable stay 1 until xfer_start, and read 0 the cycle after it.
- R10: status_o bits [4:2] are always 0, bit 1 is always 0 and bit 0 is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_rise | input | 1 | One-cycle strobe at the end of a host serial burst |
| cs_wr_tx | input | 1 | Tag: the ending burst wrote the transmit data registers |
| cs_rd_stat | input | 1 | Tag: the ending burst read the status register |
| tx_done | input | 1 | Engine finished sending the buffered transmit word |
| rx_wr | input | 1 | Engine wrote the receive registers |
| xfer_start | input | 1 | A new bus transaction starts |
| sig_mode | input | 1 | Driver is in signalling mode |
| oc_hi | input | 1 | High-side over-current comparator |
| oc_lo | input | 1 | Low-side over-current comparator |
| supply_low | input | 1 | Supply below its low-voltage threshold |
| tx_load | output | 1 | Accept strobe that loads the transmit buffer |
| status_o | output | 8 | Packed status byte |
| drv_disable | output | 1 | Forces the bus driver to high impedance |

## Verification
The bench runs each persistence filter for exactly its limit and then for one cycle more. An off-by-one counter would either trip a shutdown on a legal glitch or accept a word from a supply-qualified transfer. It writes into a full transmit buffer and raises a transmit write together with tx_done. A wrong priority would load over unsent data or lose the empty indication. It also raises a receive write together with a status read, checks that the shutdown latch survives the end of the fault and clears only at the next transaction, and checks that a fault outside signalling mode is ignored.

// File: rtl/csf_pkg.sv
package csf_pkg;
   typedef struct packed {
      logic       tx_empty;
      logic       shut;
      logic       rx_full;
      logic [2:0] rsvd;
      logic       fix_lo;
      logic       fix_hi;
   } csf_status_t;

   function automatic logic [7:0] csf_pack(input logic txe, input logic sdn, input logic rxf);
      csf_status_t s;
      s.tx_empty = txe;
      s.shut     = sdn;
      s.rx_full  = rxf;
      s.rsvd     = 3'b000;
      s.fix_lo   = 1'b0;
      s.fix_hi   = 1'b1;
      return s;
   endfunction
endpackage

// File: rtl/csf_persist.sv
module csf_persist #(
   parameter int LIMIT = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic cond,
   output logic trip
);
   localparam int CW = (LIMIT < 1) ? 1 : $clog2(LIMIT + 1);

   generate
      if (LIMIT < 0) begin : g_bad
         $error("csf_persist: LIMIT must be non-negative");
      end
      if (LIMIT == 0) begin : g_direct
         assign trip = cond;
      end else begin : g_count
         logic [CW-1:0] cnt;
         always_ff @(posedge clk) begin
            if (!rst_n || clr || !cond) cnt <= '0;
            else if (cnt != CW'(LIMIT)) cnt <= cnt + 1'b1;
         end
         assign trip = cond && (cnt == CW'(LIMIT));

         p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
            cnt <= CW'(LIMIT));
         p_trip_needs_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (!cond || clr) |=> !trip);
      end
   endgenerate
endmodule

// File: rtl/csf_tx_flag.sv
module csf_tx_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_strobe,
   input  logic tx_done,
   output logic tx_load,
   output logic tx_empty
);
   always_ff @(posedge clk) begin
      if (!rst_n)         tx_empty <= 1'b1;
      else if (tx_done)   tx_empty <= 1'b1;
      else if (tx_load)   tx_empty <= 1'b0;
   end

   assign tx_load = wr_strobe && tx_empty;

   p_txe_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_strobe && tx_empty && !tx_done) |=> !tx_empty);
   p_full_write_dropped_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_strobe && !tx_empty && !tx_done) |=> !tx_empty);
   p_txe_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      tx_done |=> tx_empty);
endmodule

// File: rtl/csf_rx_flag.sv
module csf_rx_flag #(
   parameter int SUPPLY_MASK_CYC = 12
) (
   input  logic clk,
   input  logic rst_n,
   input  logic xfer_start,
   input  logic rx_wr,
   input  logic rd_strobe,
   input  logic supply_low,
   output logic rx_full
);
   logic lv_trip, lv_seen, rx_ok;

   csf_persist #(.LIMIT(SUPPLY_MASK_CYC)) u_lv (
      .clk(clk), .rst_n(rst_n), .clr(xfer_start), .cond(supply_low), .trip(lv_trip)
   );

   always_ff @(posedge clk) begin
      if (!rst_n || xfer_start) lv_seen <= 1'b0;
      else if (lv_trip)         lv_seen <= 1'b1;
   end

   assign rx_ok = rx_wr && !lv_seen && !lv_trip;

   always_ff @(posedge clk) begin
      if (!rst_n)         rx_full <= 1'b0;
      else if (rx_ok)     rx_full <= 1'b1;
      else if (rd_strobe) rx_full <= 1'b0;
   end

   p_rx_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rx_ok |=> rx_full);
   p_rx_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_strobe && !rx_wr) |=> !rx_full);
   p_rx_qualified_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (lv_seen && !xfer_start && !rd_strobe) |=> $stable(rx_full));
endmodule

// File: rtl/csf_shutdown.sv
module csf_shutdown #(
   parameter int OC_DELAY_CYC = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic xfer_start,
   input  logic sig_mode,
   input  logic oc_hi,
   input  logic oc_lo,
   output logic shut
);
   logic oc_trip, oc_live;

   assign oc_live = sig_mode && (oc_hi || oc_lo);

   csf_persist #(.LIMIT(OC_DELAY_CYC)) u_oc (
      .clk(clk), .rst_n(rst_n), .clr(xfer_start), .cond(oc_live), .trip(oc_trip)
   );

   always_ff @(posedge clk) begin
      if (!rst_n || xfer_start) shut <= 1'b0;
      else if (oc_trip)         shut <= 1'b1;
   end

   p_shut_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (shut && !xfer_start) |=> shut);
   p_shut_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_start |=> !shut);
   p_shut_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!shut && !sig_mode) |=> !shut);
endmodule

// File: rtl/chan_status_flags.sv
module chan_status_flags #(
   parameter int OC_DELAY_CYC    = 20,
   parameter int SUPPLY_MASK_CYC = 12
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cs_rise,
   input  logic       cs_wr_tx,
   input  logic       cs_rd_stat,
   input  logic       tx_done,
   input  logic       rx_wr,
   input  logic       xfer_start,
   input  logic       sig_mode,
   input  logic       oc_hi,
   input  logic       oc_lo,
   input  logic       supply_low,
   output logic       tx_load,
   output logic [7:0] status_o,
   output logic       drv_disable
);
   import csf_pkg::*;

   generate
      if (OC_DELAY_CYC < 1) begin : g_chk_oc
         $error("chan_status_flags: OC_DELAY_CYC must be at least 1");
      end
      if (SUPPLY_MASK_CYC < 1) begin : g_chk_lv
         $error("chan_status_flags: SUPPLY_MASK_CYC must be at least 1");
      end
   endgenerate

   logic txe, rxf, sdn;

   csf_tx_flag u_tx (
      .clk(clk), .rst_n(rst_n), .wr_strobe(cs_rise && cs_wr_tx),
      .tx_done(tx_done), .tx_load(tx_load), .tx_empty(txe)
   );

   csf_rx_flag #(.SUPPLY_MASK_CYC(SUPPLY_MASK_CYC)) u_rx (
      .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .rx_wr(rx_wr),
      .rd_strobe(cs_rise && cs_rd_stat), .supply_low(supply_low), .rx_full(rxf)
   );

   csf_shutdown #(.OC_DELAY_CYC(OC_DELAY_CYC)) u_sd (
      .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .sig_mode(sig_mode),
      .oc_hi(oc_hi), .oc_lo(oc_lo), .shut(sdn)
   );

   assign status_o    = csf_pack(txe, sdn, rxf);
   assign drv_disable = sdn;

   p_fixed_bits_r10: assert property (@(posedge clk) disable iff (!rst_n)
      status_o[4:0] == 5'b00001);
   p_no_load_when_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_load && !tx_done) |=> !tx_load);
   p_reset_state_r1: assert property (@(posedge clk)
      !rst_n |=> (status_o == 8'h81 && !drv_disable));
endmodule

// File: tb/tb_chan_status_flags.sv
module tb_chan_status_flags;
   localparam int OCD = 20;
   localparam int LVM = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_rise = 0, cs_wr_tx = 0, cs_rd_stat = 0, tx_done = 0, rx_wr = 0;
   logic xfer_start = 0, sig_mode = 0, oc_hi = 0, oc_lo = 0, supply_low = 0;
   logic tx_load, drv_disable;
   logic [7:0] status_o;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   chan_status_flags #(.OC_DELAY_CYC(OCD), .SUPPLY_MASK_CYC(LVM)) dut (
      .clk(clk), .rst_n(rst_n), .cs_rise(cs_rise), .cs_wr_tx(cs_wr_tx),
      .cs_rd_stat(cs_rd_stat), .tx_done(tx_done), .rx_wr(rx_wr),
      .xfer_start(xfer_start), .sig_mode(sig_mode), .oc_hi(oc_hi), .oc_lo(oc_lo),
      .supply_low(supply_low), .tx_load(tx_load), .status_o(status_o),
      .drv_disable(drv_disable)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic idle_edge();
      @(negedge clk);
      cs_rise = 0; cs_wr_tx = 0; cs_rd_stat = 0; tx_done = 0; rx_wr = 0; xfer_start = 0;
      #1;
   endtask

   task automatic t_reset();
      check("R1 status", status_o, 8'h81);
      check("R1 drv", {7'd0, drv_disable}, 8'd0);
      check("R1 load", {7'd0, tx_load}, 8'd0);
   endtask

   task automatic t_tx();
      @(negedge clk); cs_rise = 1; cs_wr_tx = 1; #1;
      check("R2 load pulse", {7'd0, tx_load}, 8'd1);
      idle_edge();
      check("R2 txe cleared", status_o, 8'h01);
      @(negedge clk); cs_rise = 1; cs_wr_tx = 1; #1;
      check("R3 no load when full", {7'd0, tx_load}, 8'd0);
      idle_edge();
      check("R3 status unchanged", status_o, 8'h01);
      @(negedge clk); tx_done = 1;
      idle_edge();
      check("R4 txe set", status_o, 8'h81);
      @(negedge clk); cs_rise = 1; cs_wr_tx = 1;
      idle_edge();
      @(negedge clk); cs_rise = 1; cs_wr_tx = 1; tx_done = 1; #1;
      check("R3 load blocked with done", {7'd0, tx_load}, 8'd0);
      idle_edge();
      check("R4 done beats write", status_o, 8'h81);
   endtask

   task automatic t_rx();
      @(negedge clk); xfer_start = 1;
      idle_edge();
      @(negedge clk); rx_wr = 1;
      idle_edge();
      check("R5 rx set", status_o, 8'hA1);
      @(negedge clk); cs_rise = 1; cs_rd_stat = 1;
      idle_edge();
      check("R6 rx cleared", status_o, 8'h81);
      @(negedge clk); cs_rise = 1; cs_rd_stat = 1; rx_wr = 1;
      idle_edge();
      check("R6 write beats read", status_o, 8'hA1);
      @(negedge clk); cs_rise = 1; cs_rd_stat = 1;
      idle_edge();
   endtask

   task automatic t_supply();
      @(negedge clk); xfer_start = 1;
      idle_edge();
      @(negedge clk); supply_low = 1;
      repeat (LVM) @(negedge clk);
      supply_low = 0; rx_wr = 1;
      idle_edge();
      check("R7 exact mask accepted", status_o, 8'hA1);
      @(negedge clk); cs_rise = 1; cs_rd_stat = 1;
      idle_edge();
      @(negedge clk); xfer_start = 1;
      idle_edge();
      @(negedge clk); supply_low = 1;
      repeat (LVM + 1) @(negedge clk);
      supply_low = 0;
      idle_edge();
      @(negedge clk); rx_wr = 1;
      idle_edge();
      check("R7 qualified write dropped", status_o, 8'h81);
      @(negedge clk); xfer_start = 1;
      idle_edge();
      @(negedge clk); rx_wr = 1;
      idle_edge();
      check("R7 new transfer accepted", status_o, 8'hA1);
      @(negedge clk); cs_rise = 1; cs_rd_stat = 1;
      idle_edge();
   endtask

   task automatic t_shutdown();
      @(negedge clk); sig_mode = 1; oc_hi = 1;
      repeat (OCD) @(negedge clk);
      oc_hi = 0; #1;
      check("R8 exact delay no trip", {drv_disable, status_o[6:0]}, 8'h01);
      @(negedge clk); oc_lo = 1;
      repeat (OCD + 1) @(negedge clk);
      oc_lo = 0; #1;
      check("R8 trip status", status_o, 8'hC1);
      check("R8 drv disabled", {7'd0, drv_disable}, 8'd1);
      repeat (5) @(negedge clk);
      #1;
      check("R9 latched", {drv_disable, status_o[6:0]}, 8'hC1);
      @(negedge clk); xfer_start = 1;
      idle_edge();
      check("R9 cleared at start", {drv_disable, status_o[6:0]}, 8'h01);
      @(negedge clk); sig_mode = 0; oc_hi = 1;
      repeat (OCD + 5) @(negedge clk);
      oc_hi = 0; #1;
      check("R8 idle fault ignored", {drv_disable, status_o[6:0]}, 8'h01);
      check("R10 fixed bits", {3'd0, status_o[4:0]}, 8'h01);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      #1;
      t_reset();
      t_tx();
      t_rx();
      t_supply();
      t_shutdown();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #200000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule